// File: doc/BRIEF.md
# Display Controller Shadowed Register Bank

This block is the 32-bit memory-mapped register file of a display controller. Software programs the interrupt status and mask, a global control word, a configuration word, a capability word, the sizes of the two output panels (LCD and digital), and the window of the graphics layer. The window covers the base address, position, size, attributes, FIFO threshold, row increment and pixel increment. Reads are combinational from the address. Writes take effect at the clock edge where `reg_wr` is high.

The geometry registers are double-buffered. Software writes a shadow copy, and the fetch engine only sees the active copy. Each output has a small two-state sequencer with states `GO_IDLE` and `GO_ARMED`. Transition ARM (`GO_IDLE` to `GO_ARMED`) happens when a control write sets that output's GO bit. Transition FIRE (`GO_ARMED` to `GO_IDLE`) happens at the next frame-start pulse of that output, and in that same cycle the shadow copy is moved to the active copy. Transition FLUSH returns either state to `GO_IDLE` on reset or soft reset. Because of this, a frame in progress never sees a partial update. The LCD GO commits the LCD panel size and the whole graphics layer. The digital GO commits the digital panel size.

The interrupt output is a level output. A palette-loaded pulse walks the configuration load-mode field back to its post-load value.

Register offsets (byte address on `reg_addr`): 0x00 system control, 0x04 system status, 0x08 interrupt status, 0x0C interrupt mask, 0x10 control, 0x14 configuration, 0x18 capability, 0x1C LCD size, 0x20 digital size, 0x24 layer base, 0x28 layer position, 0x2C layer size, 0x30 layer attributes, 0x34 row increment, 0x38 pixel increment, 0x3C FIFO threshold.

Top module: `dsb_top`

## Requirements
- R1: `irq` is high exactly when the interrupt status AND the interrupt mask is nonzero. The mask register keeps only bits 15:0 of a write.
- R2: Each bit of `irq_event` sets its interrupt status bit. Writing the status register clears each bit written as 1. An event in the same cycle as a clear leaves the bit set.
- R3: The size registers (panel and layer) hold width-minus-one in bits 10:0 and height-minus-one in bits 26:16, and read back in that form. The layer position register holds X in bits 10:0 and Y in bits 26:16.
- R4: Control writes are masked with 0x07FF9FFF. Bit 0 drives `lcd_on` and bit 1 drives `dig_on` in the cycle after the write.
- R5: Writing control bit 5 arms the LCD GO and writing bit 6 arms the digital GO. A pending GO reads back as 1, and a later control write with that bit at 0 does not cancel it.
- R6: At a frame-start pulse of an output whose GO is pending, the shadow copy becomes active and the GO bit reads 0. The LCD GO moves the LCD size and all layer fields. The digital GO moves the digital size only. A frame-start pulse of the other output has no effect.
- R7: Writes to shadow registers do not change any active output until the matching commit.
- R8: The layer attribute register keeps 11 bits. Bit 0 is the layer enable and bits 4:1 are the pixel format.
- R9: A `palette_done` pulse changes the configuration load-mode field (bits 2:1) from 1 to 0 and from 3 to 2. It leaves the values 0 and 2 unchanged and sets no interrupt bit.
- R10: After reset: layer size reads 0 (1x1), row and pixel increments read 1, capability reads 0x161, `irq` is 0, and system status always reads 1.
- R11: Writing bit 1 of the system control register restores every register, every active copy and both GO sequencers to the reset state.
- R12: Unmapped offsets read 0. Writes to system status are ignored. The capability register keeps bits 9:0 of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| irq_event | input | IRQ_W | Interrupt source pulses |
| frame_start_lcd | input | 1 | LCD frame-start pulse |
| frame_start_dig | input | 1 | Digital output frame-start pulse |
| palette_done | input | 1 | Palette load finished pulse |
| irq | output | 1 | Level interrupt |
| lcd_on | output | 1 | LCD output enable |
| dig_on | output | 1 | Digital output enable |
| lcd_w_m1 | output | 11 | Active LCD width minus one |
| lcd_h_m1 | output | 11 | Active LCD height minus one |
| dig_w_m1 | output | 11 | Active digital width minus one |
| dig_h_m1 | output | 11 | Active digital height minus one |
| layer_attr | output | 11 | Active layer attributes |
| layer_base | output | 32 | Active layer base address |
| layer_x | output | 11 | Active layer X position |
| layer_y | output | 11 | Active layer Y position |
| layer_w_m1 | output | 11 | Active layer width minus one |
| layer_h_m1 | output | 11 | Active layer height minus one |
| layer_row_inc | output | 32 | Active row increment |
| layer_pix_inc | output | 32 | Active pixel increment |
| layer_fifo_thr | output | 32 | Active FIFO threshold |

## Verification
The hardest situation to reach is an armed GO that survives unrelated traffic. The bench arms the LCD GO and then writes the control register again with the GO bit at 0. It then fires a frame start on the digital output only. Throughout, it checks that the GO bit still reads 1 and that the active layer outputs still hold their old values. Only then does it pulse the LCD frame start and check every active field at once. The soft-reset case is reached the same way: a GO is left armed before the reset, and the bench checks that a later frame start commits nothing.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    localparam int CW = 11;

    localparam logic [7:0] A_SYSCTL = 8'h00;
    localparam logic [7:0] A_SYSSTAT = 8'h04;
    localparam logic [7:0] A_ISTAT = 8'h08;
    localparam logic [7:0] A_IMASK = 8'h0C;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_CFG = 8'h14;
    localparam logic [7:0] A_CAPS = 8'h18;
    localparam logic [7:0] A_LCDSZ = 8'h1C;
    localparam logic [7:0] A_DIGSZ = 8'h20;
    localparam logic [7:0] A_LBASE = 8'h24;
    localparam logic [7:0] A_LPOS = 8'h28;
    localparam logic [7:0] A_LSIZE = 8'h2C;
    localparam logic [7:0] A_LATTR = 8'h30;
    localparam logic [7:0] A_LROW = 8'h34;
    localparam logic [7:0] A_LPIX = 8'h38;
    localparam logic [7:0] A_LTHR = 8'h3C;

    localparam logic [31:0] CTRL_MASK = 32'h07FF_9FFF;
    localparam logic [31:0] GO_BITS = 32'h0000_0060;
    localparam logic [31:0] THR_MASK = 32'h01FF_01FF;
    localparam logic [9:0] CAPS_RST = 10'h161;

    typedef enum logic {GO_IDLE, GO_ARMED} go_state_e;

    typedef struct packed {
        logic [CW-1:0] h_m1;
        logic [CW-1:0] w_m1;
    } dim_t;

    typedef struct packed {
        logic [31:0] base;
        dim_t pos;
        dim_t size;
        logic [CW-1:0] attr;
        logic [31:0] row_inc;
        logic [31:0] pix_inc;
        logic [31:0] thr;
    } layer_t;

    localparam dim_t DIM_RST = '0;
    localparam layer_t LAYER_RST = '{base: '0, pos: '0, size: '0, attr: '0,
                                     row_inc: 32'd1, pix_inc: 32'd1, thr: '0};

    function automatic logic [31:0] pack_dim(dim_t d);
        return {{(16-CW){1'b0}}, d.h_m1, {(16-CW){1'b0}}, d.w_m1};
    endfunction

    function automatic dim_t unpack_dim(logic [31:0] v);
        return '{h_m1: v[16 +: CW], w_m1: v[0 +: CW]};
    endfunction
endpackage

// File: rtl/dsb_go_seq.sv
module dsb_go_seq
    import dsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic go_req,
    input  logic frame_start,
    output logic pending,
    output logic commit
);
    go_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GO_IDLE:  if (go_req) state_d = GO_ARMED;        // ARM
            GO_ARMED: if (frame_start) state_d = GO_IDLE;    // FIRE
            default:  state_d = GO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= GO_IDLE;
        else if (soft_rst) state_q <= GO_IDLE;               // FLUSH
        else               state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == GO_ARMED);
        commit  = pending && frame_start && !soft_rst;
    end

    p_commit_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);
    p_arm_needs_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(go_req));
    p_soft_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !pending);
endmodule

// File: rtl/dsb_irq.sv
module dsb_irq #(
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] wbits,
    input  logic [IRQ_W-1:0] event_in,
    output logic [IRQ_W-1:0] stat_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else if (soft_rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | event_in;
            if (mask_we) mask_q <= wbits;
        end
    end

    assign irq = |(stat_q & mask_q);

    p_w1c_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (&wbits) && (event_in == '0) && !soft_rst) |=> (stat_q == '0));
    p_event_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && event_in != '0) |=> ((stat_q & $past(event_in)) == $past(event_in)));
endmodule

// File: rtl/dsb_top.sv
module dsb_top
    import dsb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IRQ_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IRQ_W-1:0]  irq_event,
    input  logic              frame_start_lcd,
    input  logic              frame_start_dig,
    input  logic              palette_done,
    output logic              irq,
    output logic              lcd_on,
    output logic              dig_on,
    output logic [10:0]       lcd_w_m1,
    output logic [10:0]       lcd_h_m1,
    output logic [10:0]       dig_w_m1,
    output logic [10:0]       dig_h_m1,
    output logic [10:0]       layer_attr,
    output logic [31:0]       layer_base,
    output logic [10:0]       layer_x,
    output logic [10:0]       layer_y,
    output logic [10:0]       layer_w_m1,
    output logic [10:0]       layer_h_m1,
    output logic [31:0]       layer_row_inc,
    output logic [31:0]       layer_pix_inc,
    output logic [31:0]       layer_fifo_thr
);
    localparam int NOUT = 2;  // 0: LCD, 1: digital

    logic [31:0]      ctrl_q;
    logic [13:0]      cfg_q;
    logic [9:0]       caps_q;
    dim_t             lcd_sh, lcd_act, dig_sh, dig_act;
    layer_t           lay_sh, lay_act;
    logic [NOUT-1:0]  go_req, fs, pend, commit;
    logic [IRQ_W-1:0] stat, mask;
    logic             soft_rst, wr_cfg;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    assign soft_rst = reg_wr && hit(reg_addr, A_SYSCTL) && reg_wdata[1];
    assign wr_cfg   = reg_wr && hit(reg_addr, A_CFG);
    assign fs       = {frame_start_dig, frame_start_lcd};

    generate
        for (genvar g = 0; g < NOUT; g++) begin : g_go
            assign go_req[g] = reg_wr && hit(reg_addr, A_CTRL) && reg_wdata[5+g];
            dsb_go_seq u_seq (
                .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
                .go_req(go_req[g]), .frame_start(fs[g]),
                .pending(pend[g]), .commit(commit[g])
            );
        end
    endgenerate

    dsb_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .clr_we(reg_wr && hit(reg_addr, A_ISTAT)),
        .mask_we(reg_wr && hit(reg_addr, A_IMASK)),
        .wbits(reg_wdata[IRQ_W-1:0]), .event_in(irq_event),
        .stat_q(stat), .mask_q(mask), .irq(irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; cfg_q <= '0; caps_q <= CAPS_RST;
            lcd_sh <= DIM_RST; lcd_act <= DIM_RST;
            dig_sh <= DIM_RST; dig_act <= DIM_RST;
            lay_sh <= LAYER_RST; lay_act <= LAYER_RST;
        end else if (soft_rst) begin
            ctrl_q <= '0; cfg_q <= '0; caps_q <= CAPS_RST;
            lcd_sh <= DIM_RST; lcd_act <= DIM_RST;
            dig_sh <= DIM_RST; dig_act <= DIM_RST;
            lay_sh <= LAYER_RST; lay_act <= LAYER_RST;
        end else begin
            if (commit[0]) begin
                lay_act <= lay_sh;
                lcd_act <= lcd_sh;
            end
            if (commit[1]) dig_act <= dig_sh;
            if (palette_done) cfg_q[1] <= 1'b0;  // 1 -> 0, 3 -> 2
            if (reg_wr) begin
                case (reg_addr)
                    ADDR_W'(A_CTRL):  ctrl_q <= reg_wdata & CTRL_MASK & ~GO_BITS;
                    ADDR_W'(A_CFG):   cfg_q <= reg_wdata[13:0];
                    ADDR_W'(A_CAPS):  caps_q <= reg_wdata[9:0];
                    ADDR_W'(A_LCDSZ): lcd_sh <= unpack_dim(reg_wdata);
                    ADDR_W'(A_DIGSZ): dig_sh <= unpack_dim(reg_wdata);
                    ADDR_W'(A_LBASE): lay_sh.base <= reg_wdata;
                    ADDR_W'(A_LPOS):  lay_sh.pos <= unpack_dim(reg_wdata);
                    ADDR_W'(A_LSIZE): lay_sh.size <= unpack_dim(reg_wdata);
                    ADDR_W'(A_LATTR): lay_sh.attr <= reg_wdata[CW-1:0];
                    ADDR_W'(A_LROW):  lay_sh.row_inc <= reg_wdata;
                    ADDR_W'(A_LPIX):  lay_sh.pix_inc <= reg_wdata;
                    ADDR_W'(A_LTHR):  lay_sh.thr <= reg_wdata & THR_MASK;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_SYSSTAT): reg_rdata = 32'd1;
            ADDR_W'(A_ISTAT):   reg_rdata = 32'(stat);
            ADDR_W'(A_IMASK):   reg_rdata = 32'(mask);
            ADDR_W'(A_CTRL):    reg_rdata = ctrl_q | {25'd0, pend[1], pend[0], 5'd0};
            ADDR_W'(A_CFG):     reg_rdata = 32'(cfg_q);
            ADDR_W'(A_CAPS):    reg_rdata = 32'(caps_q);
            ADDR_W'(A_LCDSZ):   reg_rdata = pack_dim(lcd_sh);
            ADDR_W'(A_DIGSZ):   reg_rdata = pack_dim(dig_sh);
            ADDR_W'(A_LBASE):   reg_rdata = lay_sh.base;
            ADDR_W'(A_LPOS):    reg_rdata = pack_dim(lay_sh.pos);
            ADDR_W'(A_LSIZE):   reg_rdata = pack_dim(lay_sh.size);
            ADDR_W'(A_LATTR):   reg_rdata = 32'(lay_sh.attr);
            ADDR_W'(A_LROW):    reg_rdata = lay_sh.row_inc;
            ADDR_W'(A_LPIX):    reg_rdata = lay_sh.pix_inc;
            ADDR_W'(A_LTHR):    reg_rdata = lay_sh.thr;
            default:            reg_rdata = '0;
        endcase
    end

    assign lcd_on         = ctrl_q[0];
    assign dig_on         = ctrl_q[1];
    assign lcd_w_m1       = lcd_act.w_m1;
    assign lcd_h_m1       = lcd_act.h_m1;
    assign dig_w_m1       = dig_act.w_m1;
    assign dig_h_m1       = dig_act.h_m1;
    assign layer_attr     = lay_act.attr;
    assign layer_base     = lay_act.base;
    assign layer_x        = lay_act.pos.w_m1;
    assign layer_y        = lay_act.pos.h_m1;
    assign layer_w_m1     = lay_act.size.w_m1;
    assign layer_h_m1     = lay_act.size.h_m1;
    assign layer_row_inc  = lay_act.row_inc;
    assign layer_pix_inc  = lay_act.pix_inc;
    assign layer_fifo_thr = lay_act.thr;

    p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit[0] && !soft_rst) |=> ($stable(lay_act) && $stable(lcd_act)));
    p_dig_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit[1] && !soft_rst) |=> $stable(dig_act));
    p_palette_revert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (palette_done && !wr_cfg && !soft_rst && cfg_q[1]) |=>
            (!cfg_q[1] && cfg_q[2] == $past(cfg_q[2])));
endmodule

// File: tb/dsb_top_bench.sv
module dsb_top_bench;
    import dsb_pkg::*;

    localparam int K_RD = 0, K_IRQ = 1, K_LCDON = 2, K_DIGON = 3, K_LCDSZ = 4,
                   K_DIGSZ = 5, K_LPOS = 6, K_LSIZE = 7, K_LATTR = 8, K_BASE = 9,
                   K_ROW = 10, K_PIX = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_event = '0;
    logic        fs_lcd = 1'b0, fs_dig = 1'b0, pal_done = 1'b0;
    logic        irq, lcd_on, dig_on;
    logic [10:0] lcd_w_m1, lcd_h_m1, dig_w_m1, dig_h_m1, layer_attr;
    logic [10:0] layer_x, layer_y, layer_w_m1, layer_h_m1;
    logic [31:0] layer_base, layer_row_inc, layer_pix_inc, layer_fifo_thr;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    int kq[$];
    logic [31:0] eq[$];
    string rq[$];
    event ev_sample;

    always #10 clk = ~clk;

    dsb_top u_dsb_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_event(irq_event),
        .frame_start_lcd(fs_lcd), .frame_start_dig(fs_dig), .palette_done(pal_done),
        .irq(irq), .lcd_on(lcd_on), .dig_on(dig_on),
        .lcd_w_m1(lcd_w_m1), .lcd_h_m1(lcd_h_m1), .dig_w_m1(dig_w_m1), .dig_h_m1(dig_h_m1),
        .layer_attr(layer_attr), .layer_base(layer_base), .layer_x(layer_x), .layer_y(layer_y),
        .layer_w_m1(layer_w_m1), .layer_h_m1(layer_h_m1), .layer_row_inc(layer_row_inc),
        .layer_pix_inc(layer_pix_inc), .layer_fifo_thr(layer_fifo_thr)
    );

    function automatic logic [31:0] observe(int k);
        case (k)
            K_RD:    return reg_rdata;
            K_IRQ:   return {31'd0, irq};
            K_LCDON: return {31'd0, lcd_on};
            K_DIGON: return {31'd0, dig_on};
            K_LCDSZ: return {5'd0, lcd_h_m1, 5'd0, lcd_w_m1};
            K_DIGSZ: return {5'd0, dig_h_m1, 5'd0, dig_w_m1};
            K_LPOS:  return {5'd0, layer_y, 5'd0, layer_x};
            K_LSIZE: return {5'd0, layer_h_m1, 5'd0, layer_w_m1};
            K_LATTR: return {21'd0, layer_attr};
            K_BASE:  return layer_base;
            K_ROW:   return layer_row_inc;
            K_PIX:   return layer_pix_inc;
            default: return 32'hX;
        endcase
    endfunction

    // Monitor: pops expected items and compares with what the design shows.
    initial forever begin
        @(ev_sample);
        while (kq.size() > 0) begin
            int k;
            logic [31:0] e, a;
            string r;
            k = kq.pop_front(); e = eq.pop_front(); r = rq.pop_front();
            a = observe(k);
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", r, k, a, e);
            end
        end
    end

    task automatic expect_item(int k, logic [31:0] e, string r);
        kq.push_back(k); eq.push_back(e); rq.push_back(r);
        #1 -> ev_sample;
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string r);
        @(negedge clk);
        reg_addr = a;
        expect_item(K_RD, e, r);
    endtask

    task automatic pulse_lcd();
        @(negedge clk); fs_lcd = 1'b1; @(negedge clk); fs_lcd = 1'b0;
    endtask

    task automatic pulse_dig();
        @(negedge clk); fs_dig = 1'b1; @(negedge clk); fs_dig = 1'b0;
    endtask

    task automatic pulse_pal();
        @(negedge clk); pal_done = 1'b1; @(negedge clk); pal_done = 1'b0;
    endtask

    task automatic pulse_evt(logic [15:0] v);
        @(negedge clk); irq_event = v; @(negedge clk); irq_event = '0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd(A_SYSSTAT, 32'd1, "R10 sysstat");
        rd(A_CAPS, 32'h161, "R10 caps");
        rd(A_LSIZE, 32'd0, "R10 layer size");
        rd(A_LROW, 32'd1, "R10 row inc");
        rd(A_LPIX, 32'd1, "R10 pix inc");
        expect_item(K_IRQ, 0, "R10 irq");
        expect_item(K_ROW, 1, "R10 active row inc");
        expect_item(K_PIX, 1, "R10 active pix inc");
        // R12 unmapped, read-only, caps width
        rd(8'hFC, 32'd0, "R12 unmapped");
        wr(A_SYSSTAT, 32'h0);
        rd(A_SYSSTAT, 32'd1, "R12 sysstat ignores write");
        wr(A_CAPS, 32'hFFFF);
        rd(A_CAPS, 32'h3FF, "R12 caps 10 bits");
        // R4 control mask, enables
        wr(A_CTRL, 32'hFFFF_FF9F);
        rd(A_CTRL, 32'h07FF_9F9F, "R4 ctrl mask");
        expect_item(K_LCDON, 1, "R4 lcd_on");
        expect_item(K_DIGON, 1, "R4 dig_on");
        wr(A_CTRL, 32'h2);
        expect_item(K_LCDON, 0, "R4 lcd_on off");
        expect_item(K_DIGON, 1, "R4 dig_on stays");
        // R3/R8 shadow programming, R7 no effect before commit
        wr(A_LCDSZ, 32'hFFFF_FFFF);
        rd(A_LCDSZ, 32'h07FF_07FF, "R3 lcd size readback");
        wr(A_LPOS, 32'h0123_0456);
        rd(A_LPOS, 32'h0123_0456, "R3 position fields");
        wr(A_LSIZE, 32'h0010_0020);
        rd(A_LSIZE, 32'h0010_0020, "R3 layer size");
        wr(A_LATTR, 32'hFFFF_FFFF);
        rd(A_LATTR, 32'h7FF, "R8 attr 11 bits");
        wr(A_LBASE, 32'hDEAD_BEEF);
        wr(A_LROW, 32'd5);
        expect_item(K_LCDSZ, 0, "R7 lcd size held");
        expect_item(K_LPOS, 0, "R7 position held");
        expect_item(K_BASE, 0, "R7 base held");
        // R5 arm, survive rewrite and foreign frame start
        wr(A_CTRL, 32'h20);
        rd(A_CTRL, 32'h20, "R5 GO lcd pending");
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h20, "R5 GO not cancelled");
        pulse_dig();
        rd(A_CTRL, 32'h20, "R6 dig frame start ignored");
        expect_item(K_LATTR, 0, "R7 attr held while armed");
        // R6 commit
        pulse_lcd();
        rd(A_CTRL, 32'h0, "R6 GO cleared");
        expect_item(K_LCDSZ, 32'h07FF_07FF, "R6 lcd size");
        expect_item(K_LPOS, 32'h0123_0456, "R6 position");
        expect_item(K_LSIZE, 32'h0010_0020, "R6 layer size");
        expect_item(K_LATTR, 32'h7FF, "R8 active attr");
        expect_item(K_BASE, 32'hDEAD_BEEF, "R6 base");
        expect_item(K_ROW, 32'd5, "R6 row inc");
        expect_item(K_DIGSZ, 0, "R6 dig untouched");
        wr(A_DIGSZ, 32'h0001_0002);
        wr(A_CTRL, 32'h40);
        rd(A_CTRL, 32'h40, "R5 GO dig pending");
        pulse_lcd();
        expect_item(K_DIGSZ, 0, "R6 lcd frame start ignored by dig");
        pulse_dig();
        expect_item(K_DIGSZ, 32'h0001_0002, "R6 dig size");
        expect_item(K_LCDSZ, 32'h07FF_07FF, "R6 lcd unaffected");
        // R1/R2 interrupts
        pulse_evt(16'h0005);
        rd(A_ISTAT, 32'h5, "R2 status set");
        expect_item(K_IRQ, 0, "R1 masked");
        wr(A_IMASK, 32'hFFFF_0004);
        rd(A_IMASK, 32'h4, "R1 mask 16 bits");
        expect_item(K_IRQ, 1, "R1 irq high");
        wr(A_ISTAT, 32'h4);
        rd(A_ISTAT, 32'h1, "R2 w1c");
        expect_item(K_IRQ, 0, "R1 irq low");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_ISTAT; reg_wdata = 32'h1; irq_event = 16'h1;
        @(negedge clk);
        reg_wr = 1'b0; irq_event = '0;
        rd(A_ISTAT, 32'h1, "R2 event beats clear");
        wr(A_ISTAT, 32'hFFFF);
        rd(A_ISTAT, 32'h0, "R2 clear all");
        // R9 palette reversion
        wr(A_CFG, 32'h2);
        pulse_pal();
        rd(A_CFG, 32'h0, "R9 mode 1 to 0");
        wr(A_CFG, 32'h6);
        pulse_pal();
        rd(A_CFG, 32'h4, "R9 mode 3 to 2");
        pulse_pal();
        rd(A_CFG, 32'h4, "R9 mode 2 kept");
        rd(A_ISTAT, 32'h0, "R9 no interrupt");
        // R11 soft reset
        wr(A_LPOS, 32'h0005_0007);
        wr(A_IMASK, 32'h1);
        wr(A_CTRL, 32'h23);
        wr(A_SYSCTL, 32'h2);
        rd(A_CTRL, 32'h0, "R11 ctrl cleared");
        rd(A_CAPS, 32'h161, "R11 caps");
        rd(A_IMASK, 32'h0, "R11 mask");
        rd(A_LPOS, 32'h0, "R11 shadow pos");
        expect_item(K_LPOS, 0, "R11 active pos");
        expect_item(K_ROW, 1, "R11 active row inc");
        expect_item(K_LCDON, 0, "R11 lcd_on");
        pulse_lcd();
        expect_item(K_LCDSZ, 0, "R11 no commit after flush");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule